// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address and burst control stage of a synchronous burst memory. On every rising clock edge it qualifies two active-low address strobes against three chip enables. It then decides what kind of cycle the memory performs on that edge.

A cycle can begin a burst in one of two ways:
- The processor strobe, gated by chip enable 1, always begins a read.
- The controller strobe begins a read or a write, following a pre-decoded write input.

Either start captures the external address. After that, the low address bits come from a small burst counter. An active-low advance input steps the counter. With advance high the address holds, which gives a wait cycle. The order of the low bits is linear (count up with wrap) or interleaved (XOR with the beat count). A mode input, captured when the burst starts, selects the order. A deselect on a strobe edge ends the burst.

The memory array uses the registered address and the cycle code. A separate write flag tells it whether a continue or suspend cycle writes. This covers the case of a write placed one clock after a processor-strobe read start.

Top module: `burst_addr_seq`

## Requirements
- R1: With procStrobeN low and the chip selected (ce1N low, ce2 high, ce3N low), the next cycleType is 2 (begin read), cycleWr is 0 whatever writeN is, and curAddr equals the addrIn sampled at that edge.
- R2: With ce1N high, procStrobeN has no effect: it neither starts nor deselects, and the cycle is decided as if the strobe were high.
- R3: The ce2 and ce3N inputs matter only on edges where a strobe is qualified. A qualified strobe with ce2 low or ce3N high gives cycleType 1 (deselect). Without a strobe, their value does not change cycleType or curAddr.
- R4: With ctrlStrobeN low, procStrobeN not qualified, and the chip selected, cycleType is 3 (begin write) with cycleWr 1 when writeN is low, and 2 with cycleWr 0 when writeN is high. The address is captured. With ctrlStrobeN low and ce1N high, cycleType is 1. A qualified processor strobe takes precedence over the controller strobe.
- R5: During an active burst, with no strobe and advanceN high, cycleType is 5 (suspend) and curAddr is unchanged.
- R6: During an active burst, with no strobe and advanceN low, cycleType is 4 (continue) and the burst counter steps by one.
- R7: With interleaveMode low at the burst start, the low BURST_BITS of curAddr are (start + count) modulo 2^BURST_BITS.
- R8: With interleaveMode high at the burst start, the low BURST_BITS of curAddr are start XOR count.
- R9: After 2^BURST_BITS steps the low bits return to the start value. The upper address bits never change except on a burst start.
- R10: A deselect ends the burst. Until the next qualified strobe, later cycles are 0 (idle) and curAddr holds.
- R11: cycleWr is 1 on a begin write. On a continue or suspend cycle it equals NOT writeN, so a write placed one clock after a processor-strobe start, with advanceN high, uses the start address. On idle, deselect and begin read it is 0.
- R12: During and right after reset, cycleType is 0, cycleWr is 0 and curAddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_W | External address |
| procStrobeN | input | 1 | Processor address strobe, active low, masked by ce1N |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| writeN | input | 1 | Decoded write request, active low |
| interleaveMode | input | 1 | 1 selects interleaved order, 0 selects linear order |
| curAddr | output | ADDR_W | Address of the current cycle |
| cycleType | output | 3 | 0 idle, 1 deselect, 2 begin read, 3 begin write, 4 continue, 5 suspend |
| cycleWr | output | 1 | Current cycle writes |

## Verification
The bench builds the block with ADDR_W of 12 and BURST_BITS of 2. With these values a four-beat wrap in both orders completes within a few cycles, and random addresses still leave upper bits that must stay frozen across a burst. Random strobe and enable patterns then meet masking, precedence and deselect endings often enough for the per-cycle reference model to cover them. Directed runs place the wrap, the wait-cycle write and the ignored strobes at known cycles.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_DESEL = 3'd1,
    CYC_RD    = 3'd2,
    CYC_WR    = 3'd3,
    CYC_CONT  = 3'd4,
    CYC_SUSP  = 3'd5
  } cyc_e;

  typedef struct packed {
    logic load;
    logic step;
  } seqCmd_t;
endpackage

// File: rtl/bas_ctrl.sv
module bas_ctrl
  import bas_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    procStrobeN,
  input  logic    ctrlStrobeN,
  input  logic    advanceN,
  input  logic    ce1N,
  input  logic    ce2,
  input  logic    ce3N,
  input  logic    writeN,
  output seqCmd_t cmd,
  output cyc_e    cycType,
  output logic    cycWr
);
  logic selected, procGo, ctrlGo, burstActive, nextWr;
  cyc_e nextType;

  always_comb begin
    selected = !ce1N && ce2 && !ce3N;
    procGo   = !procStrobeN && !ce1N;
    ctrlGo   = !ctrlStrobeN;
    nextType = CYC_IDLE;
    nextWr   = 1'b0;
    if (procGo || ctrlGo) begin
      if (!selected)    nextType = CYC_DESEL;
      else if (procGo)  nextType = CYC_RD;
      else if (!writeN) begin
        nextType = CYC_WR;
        nextWr   = 1'b1;
      end else          nextType = CYC_RD;
    end else if (burstActive) begin
      nextType = advanceN ? CYC_SUSP : CYC_CONT;
      nextWr   = !writeN;
    end
    cmd.load = (nextType == CYC_RD) || (nextType == CYC_WR);
    cmd.step = (nextType == CYC_CONT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycType     <= CYC_IDLE;
      cycWr       <= 1'b0;
      burstActive <= 1'b0;
    end else begin
      cycType <= nextType;
      cycWr   <= nextWr;
      if (cmd.load)                  burstActive <= 1'b1;
      else if (nextType == CYC_DESEL) burstActive <= 1'b0;
    end
  end

  AST_PROC_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !ce1N && ce2 && !ce3N) |=> (cycType == CYC_RD && !cycWr)); // R1
  AST_CE1_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (ce1N && ctrlStrobeN && !burstActive) |=> (cycType == CYC_IDLE)); // R2
  AST_STROBE_DESEL: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && !ce2) |=> (cycType == CYC_DESEL)); // R3
  AST_NO_STROBE_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    ((ce1N || procStrobeN) && ctrlStrobeN) |=>
      !(cycType inside {CYC_RD, CYC_WR, CYC_DESEL})); // R10
endmodule

// File: rtl/bas_datapath.sv
module bas_datapath
  import bas_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              interleaveMode,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int UPPER_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     baseAddr;
  logic [BURST_BITS-1:0] beatCnt;
  logic                  ilvMode;
  logic [BURST_BITS-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
      ilvMode  <= 1'b0;
    end else if (cmd.load) begin
      baseAddr <= addrIn;
      beatCnt  <= '0;
      ilvMode  <= interleaveMode;
    end else if (cmd.step) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    if (ilvMode) lowBits = baseAddr[BURST_BITS-1:0] ^ beatCnt;
    else         lowBits = baseAddr[BURST_BITS-1:0] + beatCnt;
  end

  assign curAddr = {baseAddr[ADDR_W-1 -: UPPER_W], lowBits};

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.step) |=> $stable(curAddr)); // R5
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> $stable(curAddr[ADDR_W-1:BURST_BITS])); // R9
  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.load) |=>
      (curAddr[BURST_BITS-1:0] != $past(curAddr[BURST_BITS-1:0]))); // R6
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              writeN,
  input  logic              interleaveMode,
  output logic [ADDR_W-1:0] curAddr,
  output logic [2:0]        cycleType,
  output logic              cycleWr
);
  seqCmd_t cmd;
  cyc_e    cycType;

  bas_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .writeN(writeN),
    .cmd(cmd), .cycType(cycType), .cycWr(cycleWr)
  );

  bas_datapath #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addrIn(addrIn),
    .interleaveMode(interleaveMode), .curAddr(curAddr)
  );

  assign cycleType = cycType;
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 12;
  localparam int BB = 2;
  localparam int BEATS = 1 << BB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic pN = 1'b1, cN = 1'b1, aN = 1'b1, e1N = 1'b1, e2 = 1'b0, e3N = 1'b1, wN = 1'b1, ilv = 1'b0;
  logic [AW-1:0] curAddr;
  logic [2:0] cycleType;
  logic cycleWr;

  burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(BB)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobeN(pN), .ctrlStrobeN(cN),
    .advanceN(aN), .ce1N(e1N), .ce2(e2), .ce3N(e3N), .writeN(wN),
    .interleaveMode(ilv), .curAddr(curAddr), .cycleType(cycleType), .cycleWr(cycleWr)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int mBase = 0, mCnt = 0, mType = 0;
  bit mIlv = 0, mActive = 0, mWr = 0;

  function automatic int expAddr();
    int lo;
    int b = mBase % BEATS;
    lo = mIlv ? (b ^ mCnt) : ((b + mCnt) % BEATS);
    return (mBase - b) + lo;
  endfunction

  task automatic modelStep();
    bit sel = !e1N && e2 && !e3N;
    bit pg = !pN && !e1N;
    bit cg = !cN;
    mWr = 0;
    if (pg || cg) begin
      if (!sel) begin mType = 1; mActive = 0; end
      else begin
        mType = (!pg && !wN) ? 3 : 2;
        mWr = (mType == 3);
        mBase = int'(addrIn); mCnt = 0; mIlv = ilv; mActive = 1;
      end
    end else if (mActive) begin
      mWr = !wN;
      if (aN) mType = 5;
      else begin mType = 4; mCnt = (mCnt + 1) % BEATS; end
    end else mType = 0;
  endtask

  function automatic string autoTag();
    case (mType)
      0: return "R10";
      1: return "R3";
      2: return "R1";
      3: return "R4";
      4: return mIlv ? "R8" : "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag);
    checks++;
    if (int'(cycleType) != mType || int'(curAddr) != expAddr() || cycleWr != mWr) begin
      fails++;
      $display("FAIL %s: type=%0d addr=%h wr=%0d expected type=%0d addr=%h wr=%0d",
               tag, cycleType, curAddr, cycleWr, mType, expAddr(), mWr);
    end
  endtask

  task automatic run(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(tag == "" ? autoTag() : tag);
  endtask

  task automatic drive(input bit p, input bit c, input bit a, input bit c1, input bit c2,
                       input bit c3, input bit w, input bit m, input int ad);
    pN = p; cN = c; aN = a; e1N = c1; e2 = c2; e3N = c3; wN = w; ilv = m;
    addrIn = AW'(ad);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12");
    rstN = 1'b1;
    // R1 / R11: processor strobe start with write low is still a read
    drive(0, 1, 1, 0, 1, 0, 0, 0, 'h2B5); run("R1");
    // R11: write in the following wait cycle uses the start address
    drive(1, 1, 1, 0, 1, 0, 0, 0, 'h000); run("R11");
    // R7 linear steps then R9 wrap
    drive(1, 1, 0, 1, 0, 1, 1, 1, 'h777);
    run("R7"); run("R7"); run("R7"); run("R9");
    // R4 controller strobe write, interleaved
    drive(1, 0, 1, 0, 1, 0, 0, 1, 'h9A6); run("R4");
    drive(1, 1, 0, 0, 1, 0, 1, 0, 'h000);
    run("R8"); run("R8"); run("R8"); run("R9");
    // R2: processor strobe with ce1N high ignored, burst suspends
    drive(0, 1, 1, 1, 1, 0, 1, 0, 'h123); run("R2");
    drive(0, 1, 0, 1, 1, 0, 1, 0, 'h123); run("R2");
    // R3: deselect via ce2 low on strobe; R10 idle afterwards
    drive(0, 1, 0, 0, 0, 0, 1, 0, 'h456); run("R3");
    drive(1, 1, 0, 0, 1, 0, 0, 0, 'h456); run("R10");
    drive(1, 1, 0, 0, 0, 1, 0, 1, 'h321); run("R3");
    // R4: controller strobe read; precedence of processor strobe
    drive(1, 0, 1, 0, 1, 0, 1, 0, 'h0F3); run("R4");
    drive(0, 0, 1, 0, 1, 0, 0, 1, 'h5C1); run("R4");
    drive(1, 0, 1, 1, 1, 0, 0, 0, 'h5C1); run("R4");
    // R6 random mix
    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0,
            $urandom_range(0, 4) == 0, $urandom_range(0, 4) != 0, $urandom_range(0, 4) == 0,
            $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0, int'($urandom_range(0, 4095)));
      run((mActive && pN && cN && !aN) ? "R6" : "");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule